// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block holds a free-running 16-bit up-counter and a single timer channel built around it. The counter wraps to zero after it reaches a programmable reload limit. The channel serves one pin in one of two directions. In input mode it watches a pin for a chosen edge and copies the counter into the channel value register when that edge arrives. It raises a capture flag and, when a capture lands on a flag that is still set, an over-capture flag. Separate enables turn on an interrupt line and a one-cycle DMA request. In output mode the counter is compared against the channel value. The comparison gives a reference level, which is polarity-adjusted and gated onto the output pin.

A restart option clears the counter on every accepted capture, so the captured value tracks the pin period directly. Software can also raise the capture flag through a dedicated register write. All configuration goes through a simple register port. Writes take effect on the clock edge, and reads are combinational on the current address.

Register map: address 0 is control (bit0 run, bit1 restart-on-capture). Address 1 is the reload limit, which resets to 0xFFFF. Address 2 is the channel setup: [1:0] direction, [2] polarity A, [3] polarity B, [4] channel enable, [6:5] reference mode, [7] interrupt enable, [8] DMA enable. Address 3 is status (bit0 capture flag, bit1 over-capture). Address 4 is the channel value and address 5 is the counter. Address 6 is write-only: bit0 set to 1 raises the flag. Reads of addresses 6 and 7 return 0.

Top module: `tmr_ccu`

## Requirements
- R1: When run is 1 the counter advances by one per clock and returns to 0 on the clock after it equals the reload limit. A bus write to address 5 loads the counter and takes priority over counting and restart.
- R2: Edge choice in input mode follows polarity A/B (setup bits 2 and 3). A=0 selects rising edges only, A=1/B=0 selects falling edges only, and A=1/B=1 selects both. A=0/B=1 behaves as rising only.
- R3: A nonzero direction field (setup bits [1:0]) puts the channel in input mode. In input mode, bus writes to the channel value (address 4) are ignored. In output mode such writes load it.
- R4: The pin passes through two synchronizing flops. When the chosen edge is seen with the channel enabled in input mode, the channel value takes the counter value held just before the third rising clock edge after the pin change, and status bit0 becomes 1 at that edge.
- R5: A capture that occurs while status bit0 is already 1 sets status bit1.
- R6: irq equals status bit0 AND interrupt enable (setup bit 7). dma_req is high for exactly the one cycle after each capture, and only when DMA enable (setup bit 8) is 1.
- R7: Writing 1 to bit0 of address 6 sets status bit0 with no pin edge. Writing 0 there has no effect.
- R8: With restart (control bit1) set, an accepted capture clears the counter, so successive captures read the pin period minus one.
- R9: Reference mode (setup bits [6:5]) selects the reference level: 0 gives constant low, 1 gives counter equal to channel value, 2 gives counter below channel value, and 3 gives counter above channel value.
- R10: ch_out is the reference level XOR polarity A when the channel is enabled in output mode. Otherwise ch_out is 0.
- R11: A status write clears each bit written as 0 and keeps each bit written as 1. A capture in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| cap_pin | input | 1 | Asynchronous channel input pin |
| ch_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request level |
| dma_req | output | 1 | One-cycle DMA request per capture |

## Verification
The properties assume that the address, write strobe and data are stable across each rising edge. They also assume that the channel pin is a plain level that may change at any cycle, with no need for it to be held longer than one clock. The bench changes every input only on falling edges and steps the address through all registers while idle. The pin is held for several cycles at a time, so single captures, missed flag clears, restart periods and all four edge choices each occur on purpose rather than by chance.

// File: rtl/tmr_ccu.sv
module tmr_ccu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         cap_pin,
  output logic         ch_out,
  output logic         irq,
  output logic         dma_req
);
  localparam int CFG_W = 9;

  logic             run_q, restart_q;
  logic [W-1:0]     arr_q, cnt_q, cv_q;
  logic [CFG_W-1:0] cfg_q;
  logic             flag_q, ovf_q, dma_q;
  logic             s1_q, s2_q, s3_q;

  wire in_mode = |cfg_q[1:0];
  wire pol_a   = cfg_q[2];
  wire pol_b   = cfg_q[3];
  wire ch_en   = cfg_q[4];
  wire [1:0] ref_mode = cfg_q[6:5];
  wire int_en  = cfg_q[7];
  wire dma_en  = cfg_q[8];

  wire rise = s2_q & ~s3_q;
  wire fall = ~s2_q & s3_q;
  wire hit  = pol_a ? (pol_b ? (rise | fall) : fall) : rise;
  wire cap  = ch_en & in_mode & hit;

  wire wr_ctrl = wr_en && addr == 3'd0;
  wire wr_arr  = wr_en && addr == 3'd1;
  wire wr_cfg  = wr_en && addr == 3'd2;
  wire wr_stat = wr_en && addr == 3'd3;
  wire wr_cv   = wr_en && addr == 3'd4;
  wire wr_cnt  = wr_en && addr == 3'd5;
  wire wr_gen  = wr_en && addr == 3'd6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0; s2_q <= 1'b0; s3_q <= 1'b0;
    end else begin
      s1_q <= cap_pin; s2_q <= s1_q; s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; restart_q <= 1'b0;
      arr_q <= '1;
      cfg_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q     <= wdata[0];
        restart_q <= wdata[1];
      end
      if (wr_arr) arr_q <= wdata;
      if (wr_cfg) cfg_q <= wdata[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (wr_cnt)             cnt_q <= wdata;
    else if (cap && restart_q)   cnt_q <= '0;
    else if (run_q)              cnt_q <= (cnt_q == arr_q) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cv_q <= '0;
    else if (cap)                cv_q <= cnt_q;
    else if (wr_cv && !in_mode)  cv_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0; ovf_q <= 1'b0; dma_q <= 1'b0;
    end else begin
      if (cap || (wr_gen && wdata[0])) flag_q <= 1'b1;
      else if (wr_stat)                flag_q <= flag_q & wdata[0];
      if (cap && flag_q)               ovf_q <= 1'b1;
      else if (wr_stat)                ovf_q <= ovf_q & wdata[1];
      dma_q <= cap & dma_en;
    end
  end

  logic ref_lvl;
  always_comb begin
    case (ref_mode)
      2'd1:    ref_lvl = (cnt_q == cv_q);
      2'd2:    ref_lvl = (cnt_q <  cv_q);
      2'd3:    ref_lvl = (cnt_q >  cv_q);
      default: ref_lvl = 1'b0;
    endcase
  end

  assign ch_out  = ~in_mode & ch_en & (ref_lvl ^ pol_a);
  assign irq     = flag_q & int_en;
  assign dma_req = dma_q;

  always_comb begin
    case (addr)
      3'd0:    rdata = {{(W-2){1'b0}}, restart_q, run_q};
      3'd1:    rdata = arr_q;
      3'd2:    rdata = {{(W-CFG_W){1'b0}}, cfg_q};
      3'd3:    rdata = {{(W-2){1'b0}}, ovf_q, flag_q};
      3'd4:    rdata = cv_q;
      3'd5:    rdata = cnt_q;
      default: rdata = '0;
    endcase
  end
endmodule

module tmr_ccu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] arr,
  input logic [W-1:0] cv,
  input logic         run,
  input logic         restart,
  input logic         cap,
  input logic         in_mode,
  input logic         flag,
  input logic         ovf,
  input logic         irq
);
  wire cnt_wr = wr_en && addr == 3'd5;

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == arr && !cnt_wr && !(restart && cap)) |=> cnt == '0);

  p_cv_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode && !cap) |=> $stable(cv));

  p_cap_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> flag);

  p_ovf_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(flag));

  p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && cap && !cnt_wr) |=> cnt == '0);
endmodule

bind tmr_ccu tmr_ccu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .cnt(cnt_q), .arr(arr_q), .cv(cv_q), .run(run_q), .restart(restart_q),
  .cap(cap), .in_mode(in_mode), .flag(flag_q), .ovf(ovf_q), .irq(irq)
);

// File: tb/tb_tmr_ccu.sv
module tb_tmr_ccu;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        cap_pin = 1'b0;
  logic        ch_out, irq, dma_req;

  tmr_ccu dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_pin(cap_pin), .ch_out(ch_out), .irq(irq), .dma_req(dma_req)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  int m_run, m_rst, m_arr, m_cfg, m_cnt, m_cv, m_flag, m_ovf, m_dma;
  int pinq[$];

  task automatic m_reset();
    m_run = 0; m_rst = 0; m_arr = 16'hFFFF; m_cfg = 0;
    m_cnt = 0; m_cv = 0; m_flag = 0; m_ovf = 0; m_dma = 0;
    pinq = {0, 0, 0};
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int mode, pa, pb, en, w, a;
      bit r, f, sel, cap;
      int ncnt, ncv, nflag, novf;
      mode = m_cfg & 3; pa = (m_cfg >> 2) & 1; pb = (m_cfg >> 3) & 1; en = (m_cfg >> 4) & 1;
      w = int'(wdata); a = wr_en ? int'(addr) : -1;
      r = pinq[$-1] == 1 && pinq[$-2] == 0;
      f = pinq[$-1] == 0 && pinq[$-2] == 1;
      if (pa == 0) sel = r; else if (pb == 0) sel = f; else sel = r || f;
      cap = sel && en == 1 && mode != 0;
      if (a == 5) ncnt = w;
      else if (cap && m_rst == 1) ncnt = 0;
      else if (m_run == 1) ncnt = (m_cnt == m_arr) ? 0 : (m_cnt + 1) & 16'hFFFF;
      else ncnt = m_cnt;
      if (cap) ncv = m_cnt; else if (a == 4 && mode == 0) ncv = w; else ncv = m_cv;
      if (cap || (a == 6 && (w & 1) == 1)) nflag = 1;
      else if (a == 3) nflag = m_flag & w & 1;
      else nflag = m_flag;
      if (cap && m_flag == 1) novf = 1;
      else if (a == 3) novf = m_ovf & ((w >> 1) & 1);
      else novf = m_ovf;
      m_dma = (cap && ((m_cfg >> 8) & 1) == 1) ? 1 : 0;
      if (a == 0) begin m_run = w & 1; m_rst = (w >> 1) & 1; end
      if (a == 1) m_arr = w;
      if (a == 2) m_cfg = w & 16'h1FF;
      m_cnt = ncnt; m_cv = ncv; m_flag = nflag; m_ovf = novf;
      pinq.push_back(int'(cap_pin));
      if (pinq.size() > 6) void'(pinq.pop_front());
    end
  end

  function automatic int exp_rdata(int a);
    case (a)
      0: return m_run | (m_rst << 1);
      1: return m_arr;
      2: return m_cfg;
      3: return m_flag | (m_ovf << 1);
      4: return m_cv;
      5: return m_cnt;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_out();
    int rm, lvl;
    rm = (m_cfg >> 5) & 3;
    case (rm)
      1: lvl = (m_cnt == m_cv) ? 1 : 0;
      2: lvl = (m_cnt <  m_cv) ? 1 : 0;
      3: lvl = (m_cnt >  m_cv) ? 1 : 0;
      default: lvl = 0;
    endcase
    if ((m_cfg & 3) != 0 || ((m_cfg >> 4) & 1) == 0) return 0;
    return lvl ^ ((m_cfg >> 2) & 1);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic string rtag(int a);
    case (a)
      0, 1, 5: return "R1 ctrl/limit/counter";
      2:       return "R2 setup";
      3:       return "R4,R5,R7,R11 status";
      4:       return "R3,R8 channel value";
      default: return "R1 unused address";
    endcase
  endfunction

  // compare on every clock, a quarter period after the rising edge
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (rst_n) begin
      chk(rtag(int'(addr)), int'(rdata), exp_rdata(int'(addr)));
      chk("R9,R10 ch_out", int'(ch_out), exp_out());
      chk("R6 irq", int'(irq), m_flag & ((m_cfg >> 7) & 1));
      chk("R6 dma_req", int'(dma_req), m_dma);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      addr = (addr >= 3'd6) ? 3'd0 : addr + 3'd1;
    end
  endtask

  task automatic pin(input bit v);
    @(negedge clk);
    cap_pin = v;
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      pin(1'b1); idle(hi);
      pin(1'b0); idle(lo);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(8);                       // reset state of every register
    // R1: counting, wrap at the limit, counter load
    wr(1, 20); wr(0, 1); idle(50);
    wr(5, 7); idle(10);
    // R9, R10: compare modes, polarity, enable gating
    wr(4, 10); wr(2, 16 | (2 << 5)); idle(45);
    wr(2, 16 | 4 | (2 << 5)); idle(25);
    wr(2, 16 | (1 << 5)); idle(25);
    wr(2, 16 | (3 << 5)); idle(25);
    wr(2, 3 << 5); idle(10);
    // R3: input mode locks the channel value
    wr(1, 16'hFFFF);
    wr(2, 1 | 16 | 128 | 256);
    wr(4, 1234); idle(6);
    // R2, R4, R5, R6: rising captures; flag left set gives over-capture
    pulses(3, 9, 6);
    // R11: clear flag only, then everything
    wr(3, 2); idle(3); wr(3, 0); idle(3);
    // R2: falling, both, and the A=0/B=1 setting
    wr(2, 1 | 4 | 16 | 128 | 256); pulses(2, 7, 8); wr(3, 0);
    wr(2, 2 | 4 | 8 | 16 | 128 | 256); pulses(2, 5, 9); wr(3, 0);
    wr(2, 3 | 8 | 16 | 128); pulses(2, 6, 6);
    // R8: period measurement with restart
    wr(3, 0); wr(0, 3); wr(2, 1 | 16 | 256);
    pulses(5, 5, 7);
    // R11: capture coinciding with a clear keeps the flag
    pin(1'b1); idle(1); wr(3, 0); idle(4); pin(1'b0); idle(4);
    // R7: software flag set, and a zero write to it does nothing
    wr(0, 1); wr(3, 0); idle(3);
    wr(6, 0); idle(3);
    wr(6, 1); idle(4);
    wr(3, 0); wr(2, 1 | 16 | 128); wr(6, 1); idle(4);
    // capture disabled: edges ignored
    wr(3, 0); wr(2, 1 | 128); pulses(2, 4, 4); idle(4);
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule